// File: doc/BRIEF.md
# Back-End Stage Flow Controller

This block is the control state machine for one back-end pipeline stage. Instruction bundles arrive from an upstream rename stage. A downstream commit stage sends back a stall request and two squash indications: a general squash and a reorder-buffer squash. The controller decides each cycle whether the stage advances, whether the upstream stage must hold, and whether the issue queue must be told to start or stop squashing. The issue queue appears here only as a full flag and a free-entry count.

When the stage is held, bundles that are already in flight are parked in a small skid FIFO instead of being lost. When the hold clears, the controller enters an unblocking phase. In that phase the parked bundles are handed on one per cycle, oldest first. The upstream stall is kept until the FIFO is empty. A squash discards everything that is parked. The controller keeps a separate count of the cycles it spends idle, blocked, unblocking and squashing.

Top module: `stage_flow_ctrl`

## Requirements
- R1: After reset `ctrl_state` is idle (encoding 0), `up_stall` and `skid_ovf` are 0 and all four cycle counters read 0. The state encodings are: idle 0, running 1, blocked 2, unblocking 3, squashing 4.
- R2: In idle, running or unblocking, a high `dn_stall` moves the controller to blocked on the next cycle. In that cycle nothing is dispatched and a valid input bundle is pushed into the skid FIFO. The stall check wins over a squash indication in the same cycle, so `iq_squash` stays low.
- R3: In idle or running with no stall or squash, `stage_adv` is 1, `disp_valid` follows `up_valid` and `disp_bundle` equals `up_bundle` in the same cycle. Idle moves to running after the first valid bundle.
- R4: In blocked, `up_stall` is 1 and `stage_adv` and `disp_valid` are 0 every cycle, and each valid input bundle is pushed. The controller moves to unblocking once `dn_stall` and `iq_full` are both low.
- R5: In unblocking, one parked bundle per cycle leaves on `disp_bundle`, in arrival order. Bundles that arrive during this phase are queued behind the parked ones. `up_stall` stays 1 while bundles would remain after the current cycle. In the cycle the FIFO drains, `up_stall` is 0 and the next state is running.
- R6: `dn_squash` or `dn_rob_squash` seen in blocked, or in an active state without `dn_stall`, pulses `iq_squash` for that cycle. The next state is squashing, and the skid FIFO is emptied.
- R7: In squashing, the controller stays while either squash input is high. It dispatches nothing and drops inputs. In the first cycle with both inputs low, `iq_squash_stop` pulses and the next state is running.
- R8: The skid FIFO holds `SKID_DEPTH` bundles (default 4). A push while it is full is dropped and sets `skid_ovf`, which stays set until reset.
- R9: `cnt_idle`, `cnt_block`, `cnt_unblock` and `cnt_squash` each add one at every clock edge where the controller is in the matching state. The new value is visible after that edge.
- R10: `iq_free_out` equals `iq_free_in` in the same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| up_valid | input | 1 | Upstream bundle present |
| up_bundle | input | BUNDLE_W | Upstream bundle payload |
| dn_stall | input | 1 | Downstream stall request |
| dn_squash | input | 1 | Downstream squash indication |
| dn_rob_squash | input | 1 | Reorder-buffer squash indication |
| iq_full | input | 1 | Issue queue full |
| iq_free_in | input | IQ_CNT_W | Free issue-queue entries |
| up_stall | output | 1 | Stall to upstream stage |
| iq_free_out | output | IQ_CNT_W | Free entries reported upstream |
| stage_adv | output | 1 | Stage advance enable |
| disp_valid | output | 1 | Bundle dispatched this cycle |
| disp_bundle | output | BUNDLE_W | Dispatched bundle |
| iq_squash | output | 1 | Start-squash command to issue queue |
| iq_squash_stop | output | 1 | Stop-squash command to issue queue |
| skid_ovf | output | 1 | Sticky skid overflow flag |
| ctrl_state | output | 3 | Current controller state |
| cnt_idle | output | CYC_CNT_W | Idle cycle count |
| cnt_squash | output | CYC_CNT_W | Squashing cycle count |
| cnt_block | output | CYC_CNT_W | Blocked cycle count |
| cnt_unblock | output | CYC_CNT_W | Unblocking cycle count |

## Verification
Two pairs of functions can fall in the same cycle here. The first pair is a stall request and a squash indication. The bench raises both together while running and expects the stall to win: blocked next, no `iq_squash`. It then holds the squash while blocked and expects squashing next, with the parked bundle never dispatched. The second pair is a pop and a push in the same unblocking cycle. The bench sends a new bundle mid-drain, and the scoreboard judges the dispatch order and the exact cycle `up_stall` falls.

// File: rtl/stage_flow_pkg.sv
package stage_flow_pkg;

    typedef enum logic [2:0] {
        ST_IDLE   = 3'd0,
        ST_RUN    = 3'd1,
        ST_BLOCK  = 3'd2,
        ST_UNBLK  = 3'd3,
        ST_SQUASH = 3'd4
    } ctrl_state_e;

    localparam int unsigned NUM_CYC_CNT = 4;

    // counter slot order
    localparam int unsigned CC_IDLE   = 0;
    localparam int unsigned CC_SQUASH = 1;
    localparam int unsigned CC_BLOCK  = 2;
    localparam int unsigned CC_UNBLK  = 3;

    typedef struct packed {
        logic push;
        logic pop;
        logic flush;
    } skid_cmd_t;

    function automatic logic is_active(ctrl_state_e s);
        return (s == ST_IDLE) || (s == ST_RUN) || (s == ST_UNBLK);
    endfunction

    function automatic logic squash_req(logic sq, logic rob_sq);
        return sq | rob_sq;
    endfunction

    function automatic ctrl_state_e counter_state(int unsigned idx);
        case (idx)
            CC_IDLE:   return ST_IDLE;
            CC_SQUASH: return ST_SQUASH;
            CC_BLOCK:  return ST_BLOCK;
            default:   return ST_UNBLK;
        endcase
    endfunction

endpackage

// File: rtl/sfc_skid_fifo.sv
module sfc_skid_fifo
    import stage_flow_pkg::*;
#(
    parameter int unsigned DATA_W = 32,
    parameter int unsigned DEPTH  = 4,
    localparam int unsigned PTR_W = (DEPTH > 1) ? $clog2(DEPTH) : 1,
    localparam int unsigned CNT_W = $clog2(DEPTH + 1)
) (
    input  logic              clk,
    input  logic              rst,
    input  skid_cmd_t         cmd,
    input  logic [DATA_W-1:0] data_in,
    output logic [DATA_W-1:0] head,
    output logic [CNT_W-1:0]  count,
    output logic              ovf
);

    logic [DATA_W-1:0] mem [DEPTH];
    logic [PTR_W-1:0]  wr_ptr;
    logic [PTR_W-1:0]  rd_ptr;
    logic              empty;
    logic              full;
    logic              do_pop;
    logic              do_push;

    function automatic logic [PTR_W-1:0] ptr_inc(logic [PTR_W-1:0] p);
        return (p == PTR_W'(DEPTH - 1)) ? '0 : p + 1'b1;
    endfunction

    assign empty   = (count == '0);
    assign full    = (count == CNT_W'(DEPTH));
    assign do_pop  = cmd.pop && !empty;
    assign do_push = cmd.push && (!full || do_pop);
    assign head    = mem[rd_ptr];

    always_ff @(posedge clk) begin
        if (rst || cmd.flush) begin
            wr_ptr <= '0;
            rd_ptr <= '0;
            count  <= '0;
        end else begin
            if (do_push) wr_ptr <= ptr_inc(wr_ptr);
            if (do_pop)  rd_ptr <= ptr_inc(rd_ptr);
            count <= count + CNT_W'(do_push) - CNT_W'(do_pop);
        end
    end

    always_ff @(posedge clk) begin
        if (do_push && !cmd.flush) mem[wr_ptr] <= data_in;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            ovf <= 1'b0;
        end else if (cmd.push && full && !do_pop && !cmd.flush) begin
            ovf <= 1'b1;
        end
    end

endmodule

// File: rtl/sfc_fsm.sv
module sfc_fsm
    import stage_flow_pkg::*;
#(
    parameter int unsigned SKID_CNT_W = 3
) (
    input  logic                  clk,
    input  logic                  rst,
    input  logic                  up_valid,
    input  logic                  dn_stall,
    input  logic                  dn_squash,
    input  logic                  dn_rob_squash,
    input  logic                  iq_full,
    input  logic [SKID_CNT_W-1:0] skid_count,
    output ctrl_state_e           state,
    output skid_cmd_t             skid_cmd,
    output logic                  up_stall,
    output logic                  stage_adv,
    output logic                  disp_valid,
    output logic                  disp_from_skid,
    output logic                  iq_squash,
    output logic                  iq_squash_stop
);

    ctrl_state_e next_state;
    logic        sq_any;
    logic        skid_has;
    logic        skid_left;

    assign sq_any    = squash_req(dn_squash, dn_rob_squash);
    assign skid_has  = (skid_count != '0);
    // bundles still parked after this cycle's pop (and possible push)
    assign skid_left = (skid_count > SKID_CNT_W'(1)) || up_valid;

    always_comb begin
        next_state     = state;
        skid_cmd       = '0;
        up_stall       = 1'b0;
        stage_adv      = 1'b0;
        disp_valid     = 1'b0;
        disp_from_skid = 1'b0;
        iq_squash      = 1'b0;
        iq_squash_stop = 1'b0;
        case (state)
            ST_IDLE, ST_RUN, ST_UNBLK: begin
                if (dn_stall) begin
                    next_state    = ST_BLOCK;
                    skid_cmd.push = up_valid;
                    up_stall      = 1'b1;
                end else if (sq_any) begin
                    next_state     = ST_SQUASH;
                    skid_cmd.flush = 1'b1;
                    iq_squash      = 1'b1;
                end else if (state == ST_UNBLK) begin
                    stage_adv = 1'b1;
                    if (skid_has) begin
                        disp_valid     = 1'b1;
                        disp_from_skid = 1'b1;
                        skid_cmd.pop   = 1'b1;
                        skid_cmd.push  = up_valid;
                        if (skid_left) up_stall = 1'b1;
                        else           next_state = ST_RUN;
                    end else begin
                        disp_valid = up_valid;
                        next_state = ST_RUN;
                    end
                end else begin
                    stage_adv  = 1'b1;
                    disp_valid = up_valid;
                    if (state == ST_IDLE && up_valid) next_state = ST_RUN;
                end
            end
            ST_BLOCK: begin
                up_stall = 1'b1;
                if (sq_any) begin
                    next_state     = ST_SQUASH;
                    skid_cmd.flush = 1'b1;
                    iq_squash      = 1'b1;
                end else begin
                    skid_cmd.push = up_valid;
                    if (!dn_stall && !iq_full) next_state = ST_UNBLK;
                end
            end
            ST_SQUASH: begin
                if (!sq_any) begin
                    next_state     = ST_RUN;
                    iq_squash_stop = 1'b1;
                end
            end
            default: next_state = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) state <= ST_IDLE;
        else     state <= next_state;
    end

endmodule

// File: rtl/sfc_cycle_counters.sv
module sfc_cycle_counters
    import stage_flow_pkg::*;
#(
    parameter int unsigned CNT_W = 16
) (
    input  logic                                 clk,
    input  logic                                 rst,
    input  ctrl_state_e                          state,
    output logic [NUM_CYC_CNT-1:0][CNT_W-1:0]    counts
);

    for (genvar i = 0; i < NUM_CYC_CNT; i++) begin : g_cnt
        localparam ctrl_state_e MATCH = counter_state(i);
        always_ff @(posedge clk) begin
            if (rst)                 counts[i] <= '0;
            else if (state == MATCH) counts[i] <= counts[i] + 1'b1;
        end
    end

endmodule

// File: rtl/stage_flow_ctrl.sv
module stage_flow_ctrl
    import stage_flow_pkg::*;
#(
    parameter int unsigned BUNDLE_W   = 32,
    parameter int unsigned SKID_DEPTH = 4,
    parameter int unsigned IQ_CNT_W   = 6,
    parameter int unsigned CYC_CNT_W  = 16,
    localparam int unsigned SKID_CNT_W = $clog2(SKID_DEPTH + 1)
) (
    input  logic                 clk,
    input  logic                 rst,
    input  logic                 up_valid,
    input  logic [BUNDLE_W-1:0]  up_bundle,
    input  logic                 dn_stall,
    input  logic                 dn_squash,
    input  logic                 dn_rob_squash,
    input  logic                 iq_full,
    input  logic [IQ_CNT_W-1:0]  iq_free_in,
    output logic                 up_stall,
    output logic [IQ_CNT_W-1:0]  iq_free_out,
    output logic                 stage_adv,
    output logic                 disp_valid,
    output logic [BUNDLE_W-1:0]  disp_bundle,
    output logic                 iq_squash,
    output logic                 iq_squash_stop,
    output logic                 skid_ovf,
    output logic [2:0]           ctrl_state,
    output logic [CYC_CNT_W-1:0] cnt_idle,
    output logic [CYC_CNT_W-1:0] cnt_squash,
    output logic [CYC_CNT_W-1:0] cnt_block,
    output logic [CYC_CNT_W-1:0] cnt_unblock
);

    ctrl_state_e                            state;
    skid_cmd_t                              skid_cmd;
    logic [SKID_CNT_W-1:0]                  skid_count;
    logic [BUNDLE_W-1:0]                    skid_head;
    logic                                   disp_from_skid;
    logic [NUM_CYC_CNT-1:0][CYC_CNT_W-1:0]  counts;

    sfc_fsm #(.SKID_CNT_W(SKID_CNT_W)) u_fsm (
        .clk            (clk),
        .rst            (rst),
        .up_valid       (up_valid),
        .dn_stall       (dn_stall),
        .dn_squash      (dn_squash),
        .dn_rob_squash  (dn_rob_squash),
        .iq_full        (iq_full),
        .skid_count     (skid_count),
        .state          (state),
        .skid_cmd       (skid_cmd),
        .up_stall       (up_stall),
        .stage_adv      (stage_adv),
        .disp_valid     (disp_valid),
        .disp_from_skid (disp_from_skid),
        .iq_squash      (iq_squash),
        .iq_squash_stop (iq_squash_stop)
    );

    sfc_skid_fifo #(.DATA_W(BUNDLE_W), .DEPTH(SKID_DEPTH)) u_skid (
        .clk     (clk),
        .rst     (rst),
        .cmd     (skid_cmd),
        .data_in (up_bundle),
        .head    (skid_head),
        .count   (skid_count),
        .ovf     (skid_ovf)
    );

    sfc_cycle_counters #(.CNT_W(CYC_CNT_W)) u_cnt (
        .clk    (clk),
        .rst    (rst),
        .state  (state),
        .counts (counts)
    );

    assign disp_bundle = disp_from_skid ? skid_head : up_bundle;
    assign iq_free_out = iq_free_in;
    assign ctrl_state  = state;
    assign cnt_idle    = counts[CC_IDLE];
    assign cnt_squash  = counts[CC_SQUASH];
    assign cnt_block   = counts[CC_BLOCK];
    assign cnt_unblock = counts[CC_UNBLK];

endmodule

// File: rtl/stage_flow_ctrl_chk.sv
module stage_flow_ctrl_chk
    import stage_flow_pkg::*;
#(
    parameter int unsigned SKID_DEPTH = 4,
    parameter int unsigned SKID_CNT_W = 3,
    parameter int unsigned CYC_CNT_W  = 16
) (
    input logic                  clk,
    input logic                  rst,
    input logic [2:0]            ctrl_state,
    input logic                  dn_stall,
    input logic                  dn_squash,
    input logic                  dn_rob_squash,
    input logic                  up_stall,
    input logic                  stage_adv,
    input logic                  disp_valid,
    input logic [SKID_CNT_W-1:0] skid_count,
    input logic                  skid_ovf,
    input logic [CYC_CNT_W-1:0]  cnt_idle
);

    logic sq_in;
    logic act;
    assign sq_in = dn_squash | dn_rob_squash;
    assign act   = (ctrl_state == ST_IDLE) || (ctrl_state == ST_RUN) || (ctrl_state == ST_UNBLK);

    p_reset_idle_r1: assert property (@(posedge clk) disable iff (rst)
        $past(rst) |-> (ctrl_state == ST_IDLE && !skid_ovf && cnt_idle == '0));

    p_stall_wins_r2: assert property (@(posedge clk) disable iff (rst)
        (act && dn_stall) |=> (ctrl_state == ST_BLOCK));

    p_block_holds_r4: assert property (@(posedge clk) disable iff (rst)
        (ctrl_state == ST_BLOCK) |-> (up_stall && !stage_adv && !disp_valid));

    p_unblk_stall_r5: assert property (@(posedge clk) disable iff (rst)
        (ctrl_state == ST_UNBLK && !dn_stall && !sq_in && skid_count > SKID_CNT_W'(1)) |-> up_stall);

    p_block_squash_r6: assert property (@(posedge clk) disable iff (rst)
        (ctrl_state == ST_BLOCK && sq_in) |=> (ctrl_state == ST_SQUASH && skid_count == '0));

    p_squash_hold_r7: assert property (@(posedge clk) disable iff (rst)
        (ctrl_state == ST_SQUASH && sq_in) |=> (ctrl_state == ST_SQUASH));

    p_squash_exit_r7: assert property (@(posedge clk) disable iff (rst)
        (ctrl_state == ST_SQUASH && !sq_in) |=> (ctrl_state == ST_RUN));

    p_ovf_sticky_r8: assert property (@(posedge clk) disable iff (rst)
        skid_ovf |=> skid_ovf);

    p_skid_bound_r8: assert property (@(posedge clk) disable iff (rst)
        skid_count <= SKID_CNT_W'(SKID_DEPTH));

    p_idle_count_r9: assert property (@(posedge clk) disable iff (rst)
        (ctrl_state == ST_IDLE) |=> (cnt_idle == CYC_CNT_W'($past(cnt_idle) + 1'b1)));

endmodule

bind stage_flow_ctrl stage_flow_ctrl_chk #(
    .SKID_DEPTH (SKID_DEPTH),
    .SKID_CNT_W (SKID_CNT_W),
    .CYC_CNT_W  (CYC_CNT_W)
) u_chk (
    .clk           (clk),
    .rst           (rst),
    .ctrl_state    (ctrl_state),
    .dn_stall      (dn_stall),
    .dn_squash     (dn_squash),
    .dn_rob_squash (dn_rob_squash),
    .up_stall      (up_stall),
    .stage_adv     (stage_adv),
    .disp_valid    (disp_valid),
    .skid_count    (skid_count),
    .skid_ovf      (skid_ovf),
    .cnt_idle      (cnt_idle)
);

// File: tb/test_stage_flow_ctrl.sv
`timescale 1ns/1ps
module test_stage_flow_ctrl;

    localparam int BW  = 32;
    localparam int IQW = 6;
    localparam int CW  = 16;

    logic clk = 1'b0;
    always #2 clk = ~clk;

    logic           rst = 1'b1;
    logic           up_valid = 1'b0;
    logic [BW-1:0]  up_bundle = '0;
    logic           dn_stall = 1'b0;
    logic           dn_squash = 1'b0;
    logic           dn_rob_squash = 1'b0;
    logic           iq_full = 1'b0;
    logic [IQW-1:0] iq_free_in = '0;
    logic           up_stall;
    logic [IQW-1:0] iq_free_out;
    logic           stage_adv;
    logic           disp_valid;
    logic [BW-1:0]  disp_bundle;
    logic           iq_squash;
    logic           iq_squash_stop;
    logic           skid_ovf;
    logic [2:0]     ctrl_state;
    logic [CW-1:0]  cnt_idle;
    logic [CW-1:0]  cnt_squash;
    logic [CW-1:0]  cnt_block;
    logic [CW-1:0]  cnt_unblock;

    stage_flow_ctrl i_stage_flow_ctrl (
        .clk(clk), .rst(rst), .up_valid(up_valid), .up_bundle(up_bundle),
        .dn_stall(dn_stall), .dn_squash(dn_squash), .dn_rob_squash(dn_rob_squash),
        .iq_full(iq_full), .iq_free_in(iq_free_in), .up_stall(up_stall),
        .iq_free_out(iq_free_out), .stage_adv(stage_adv), .disp_valid(disp_valid),
        .disp_bundle(disp_bundle), .iq_squash(iq_squash), .iq_squash_stop(iq_squash_stop),
        .skid_ovf(skid_ovf), .ctrl_state(ctrl_state), .cnt_idle(cnt_idle),
        .cnt_squash(cnt_squash), .cnt_block(cnt_block), .cnt_unblock(cnt_unblock)
    );

    int            checks = 0;
    int            errors = 0;
    bit            finished = 0;
    logic [BW-1:0] exp_q[$];

    task automatic chk(input string req, input string what, input longint act, input longint exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s %s actual %0h expected %0h", req, what, act, exp);
        end
    endtask

    // driver: apply inputs after an edge, queue the expected dispatch, return mid-cycle
    task automatic step(input logic v, input logic [BW-1:0] d, input logic st,
                        input logic sq, input logic rb, input logic full, input bit ex);
        @(posedge clk);
        #1;
        up_valid      = v;
        up_bundle     = d;
        dn_stall      = st;
        dn_squash     = sq;
        dn_rob_squash = rb;
        iq_full       = full;
        if (ex) exp_q.push_back(d);
        @(negedge clk);
    endtask

    // monitor: every dispatched bundle must match the oldest expected one (R3 R5)
    always @(negedge clk) begin
        if (!rst && disp_valid) begin
            checks++;
            if (exp_q.size() == 0) begin
                errors++;
                $display("FAIL R5 unexpected dispatch actual %0h expected none", disp_bundle);
            end else begin
                logic [BW-1:0] e;
                e = exp_q.pop_front();
                if (disp_bundle != e) begin
                    errors++;
                    $display("FAIL R5 dispatch order actual %0h expected %0h", disp_bundle, e);
                end
            end
        end
    end

    initial begin
        repeat (100000) @(posedge clk);
        if (!finished) begin
            checks++;
            errors++;
            $display("FAIL watchdog expired actual running expected done");
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        repeat (3) @(posedge clk);
        #1 rst = 1'b0;
        @(negedge clk);
        chk("R1", "state", ctrl_state, 0);
        chk("R1", "up_stall", up_stall, 0);
        chk("R1", "skid_ovf", skid_ovf, 0);
        chk("R1", "counters", {cnt_idle, cnt_squash, cnt_block, cnt_unblock}, 0);

        repeat (3) step(0, '0, 0, 0, 0, 0, 0);
        chk("R9", "cnt_idle", cnt_idle, 3);

        step(1, 32'hA1, 0, 0, 0, 0, 1);
        chk("R3", "stage_adv idle", stage_adv, 1);
        step(1, 32'hA2, 0, 0, 0, 0, 1);
        chk("R3", "state after first bundle", ctrl_state, 1);
        step(1, 32'hA3, 0, 0, 0, 0, 1);

        // stall while running, then blocked with queue full
        step(1, 32'hB1, 1, 0, 0, 0, 1);
        chk("R2", "no dispatch on stall", disp_valid, 0);
        step(1, 32'hB2, 1, 0, 0, 0, 1);
        chk("R4", "state blocked", ctrl_state, 2);
        chk("R4", "up_stall blocked", up_stall, 1);
        chk("R4", "stage_adv blocked", stage_adv, 0);
        step(1, 32'hB3, 0, 0, 0, 1, 1);
        step(0, '0, 0, 0, 0, 0, 0);
        chk("R4", "still blocked while iq full", ctrl_state, 2);
        step(0, '0, 0, 0, 0, 0, 0);
        chk("R5", "state unblocking", ctrl_state, 3);
        chk("R5", "stall while draining", up_stall, 1);
        step(1, 32'hB4, 0, 0, 0, 0, 1);
        chk("R5", "stall with push and pop", up_stall, 1);
        step(0, '0, 0, 0, 0, 0, 0);
        chk("R5", "stall two left", up_stall, 1);
        step(0, '0, 0, 0, 0, 0, 0);
        chk("R5", "stall released on drain", up_stall, 0);
        step(0, '0, 0, 0, 0, 0, 0);
        chk("R5", "running after drain", ctrl_state, 1);
        chk("R9", "cnt_block", cnt_block, 3);
        chk("R9", "cnt_unblock", cnt_unblock, 4);

        // overflow of the skid FIFO
        step(1, 32'hC1, 1, 0, 0, 0, 1);
        step(1, 32'hC2, 1, 0, 0, 0, 1);
        step(1, 32'hC3, 1, 0, 0, 0, 1);
        step(1, 32'hC4, 1, 0, 0, 0, 1);
        chk("R8", "no overflow at depth", skid_ovf, 0);
        step(1, 32'hC5, 1, 0, 0, 0, 0);
        step(0, '0, 0, 0, 0, 0, 0);
        chk("R8", "overflow flag", skid_ovf, 1);
        repeat (4) step(0, '0, 0, 0, 0, 0, 0);
        step(0, '0, 0, 0, 0, 0, 0);
        chk("R8", "overflow sticky", skid_ovf, 1);
        chk("R8", "dropped bundle not dispatched", exp_q.size(), 0);

        // squash from running
        step(1, 32'hD1, 0, 1, 0, 0, 0);
        chk("R6", "iq_squash pulse", iq_squash, 1);
        chk("R6", "no dispatch on squash", disp_valid, 0);
        step(0, '0, 0, 1, 0, 0, 0);
        chk("R7", "state squashing", ctrl_state, 4);
        chk("R6", "squash pulse single", iq_squash, 0);
        step(1, 32'hD2, 0, 0, 1, 0, 0);
        chk("R7", "hold on rob squash", iq_squash_stop, 0);
        step(0, '0, 0, 0, 0, 0, 0);
        chk("R7", "stop pulse", iq_squash_stop, 1);
        step(0, '0, 0, 0, 0, 0, 0);
        chk("R7", "running after squash", ctrl_state, 1);
        chk("R9", "cnt_squash", cnt_squash, 3);

        // stall and squash together, then squash while blocked
        step(1, 32'hE1, 1, 1, 0, 0, 0);
        chk("R2", "stall beats squash", iq_squash, 0);
        step(1, 32'hE2, 0, 1, 0, 0, 0);
        chk("R6", "squash from blocked", iq_squash, 1);
        step(0, '0, 0, 0, 0, 0, 0);
        chk("R6", "state squashing", ctrl_state, 4);
        step(1, 32'hF1, 0, 0, 0, 0, 1);
        chk("R6", "running after flush", ctrl_state, 1);

        iq_free_in = 6'd17;
        step(0, '0, 0, 0, 0, 0, 0);
        chk("R10", "free count passthrough", iq_free_out, 17);
        chk("R6", "flushed bundle never dispatched", exp_q.size(), 0);

        finished = 1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule